// File: doc/BRIEF.md
# Extended Register-Pair and Bit-Manipulation ALU

This unit executes a small group of extra operations that an extended 8-bit core adds beside its classic ALU. The decoder hands it the second opcode byte of a prefixed instruction, together with the current accumulator, flag byte, the three 16-bit register pairs and an optional 16-bit immediate. One clock later the unit presents the updated register values and an updated flag byte. A write-enable for each destination tells the register file which values to take.

The supported work is:
- a register pair plus the zero-extended accumulator;
- a register pair plus a 16-bit immediate;
- an unsigned 8x8 multiply of the two halves of DE, written back into DE;
- a bit-order reversal of the accumulator;
- a nibble exchange of the accumulator;
- a flag-only AND against an immediate byte.

Instruction fetch, prefix decode and memory traffic are handled elsewhere.

Top module: `xalu_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every write-enable and `outValid` are low and all result outputs are zero.
- R2: An operation presented with `opValid` high on a rising edge shows its results on the outputs after that edge, so the latency is one cycle. A cycle with `opValid` low gives all write-enables low and `outValid` low after the next edge. A result output whose write-enable is low repeats the input value sampled on that edge.
- R3: Opcodes 0x31, 0x32 and 0x33 add `inA`, zero-extended to 16 bits, to HL, DE and BC respectively, modulo 2^16. Only that pair's write-enable is raised.
- R4: Opcodes 0x34, 0x35 and 0x36 add `inImm` to HL, DE and BC respectively, modulo 2^16. Only that pair's write-enable is raised.
- R5: The pair-add opcodes of R3 and R4 never raise `weF`, and `outF` equals `inF`.
- R6: Opcode 0x30 writes DE with the unsigned 16-bit product of D (bits 15:8) and E (bits 7:0). `weDE` is the only write-enable raised, so the flags are kept.
- R7: Opcode 0x24 writes A with its bits reversed (bit 0 moves to bit 7 and so on). Only `weA` is raised.
- R8: Opcode 0x23 writes A with its upper and lower 4-bit halves exchanged. Only `weA` is raised.
- R9: Opcode 0x27 forms r = `inA` AND `inImm[7:0]` and writes only the flag byte. The bit layout is bit7 = r[7], bit6 = (r==0), bit5 = r[5], bit4 = 1, bit3 = r[3], bit2 = 1 when r has an even number of ones, bit1 = 0 and bit0 = 0. `weA` stays low and `outA` equals `inA`.
- R10: Any other opcode value raises no write-enable, while `outValid` is still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 8 | Second opcode byte after the prefix |
| inA | input | 8 | Accumulator value |
| inF | input | 8 | Flag byte value |
| inBC | input | 16 | BC pair value |
| inDE | input | 16 | DE pair value |
| inHL | input | 16 | HL pair value |
| inImm | input | 16 | Immediate operand (byte ops use bits 7:0) |
| outA | output | 8 | Resulting accumulator |
| outF | output | 8 | Resulting flag byte |
| outBC | output | 16 | Resulting BC |
| outDE | output | 16 | Resulting DE |
| outHL | output | 16 | Resulting HL |
| weA | output | 1 | Write accumulator |
| weF | output | 1 | Write flag byte |
| weBC | output | 1 | Write BC |
| weDE | output | 1 | Write DE |
| weHL | output | 1 | Write HL |
| outValid | output | 1 | Outputs correspond to an operation issued the previous cycle |

## Verification
Random operands are drawn across the full 8- and 16-bit ranges for every defined opcode, interleaved with undefined opcodes and idle cycles. This separates a wrong pair selection, a missing zero-extension and a wrong write-enable from a correct result. Directed cases cover the edges:
- additions that wrap past 0xFFFF;
- a 0xFF by 0xFF product, and multiplies by zero;
- mirror and nibble patterns with a single set bit, where a swapped index shows at once;
- a TEST whose result is zero, and TEST results of odd and even parity, which separate the Z and P/V flags from the copied result bits.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

  // Second opcode byte values; the decoder upstream depends on these codes.
  localparam logic [7:0] OP_SWAPNIB = 8'h23;
  localparam logic [7:0] OP_MIRROR  = 8'h24;
  localparam logic [7:0] OP_TESTIMM = 8'h27;
  localparam logic [7:0] OP_MULDE   = 8'h30;
  localparam logic [7:0] OP_ADDHL_A = 8'h31;
  localparam logic [7:0] OP_ADDDE_A = 8'h32;
  localparam logic [7:0] OP_ADDBC_A = 8'h33;
  localparam logic [7:0] OP_ADDHL_N = 8'h34;
  localparam logic [7:0] OP_ADDDE_N = 8'h35;
  localparam logic [7:0] OP_ADDBC_N = 8'h36;

  // Flag byte bit positions (fixed by the core's flag register layout).
  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_Y  = 5;
  localparam int FLAG_H  = 4;
  localparam int FLAG_X  = 3;
  localparam int FLAG_PV = 2;
  localparam int FLAG_N  = 1;
  localparam int FLAG_C  = 0;

  // Strobes from control to datapath.
  typedef struct packed {
    logic live;       // operation presented this cycle
    logic selSwap;
    logic selMirror;
    logic selTest;
    logic selMul;
    logic selAddA;
    logic selAddImm;
    logic pairHL;
    logic pairDE;
    logic pairBC;
    logic wrA;
    logic wrF;
    logic wrBC;
    logic wrDE;
    logic wrHL;
  } xaluStrobe_t;

endpackage

// File: rtl/xalu_ctrl.sv
module xalu_ctrl
  import xalu_pkg::*;
(
  input  logic        opValid,
  input  logic [7:0]  opCode,
  output xaluStrobe_t stb
);

  logic isAddA;
  logic isAddImm;
  logic isMul;
  logic isMirror;
  logic isSwap;
  logic isTest;
  logic [2:0] pairOneHot; // {HL, DE, BC}

  always_comb begin
    isAddA     = 1'b0;
    isAddImm   = 1'b0;
    isMul      = 1'b0;
    isMirror   = 1'b0;
    isSwap     = 1'b0;
    isTest     = 1'b0;
    pairOneHot = 3'b000;
    unique case (opCode)
      OP_ADDHL_A: begin isAddA   = 1'b1; pairOneHot = 3'b100; end
      OP_ADDDE_A: begin isAddA   = 1'b1; pairOneHot = 3'b010; end
      OP_ADDBC_A: begin isAddA   = 1'b1; pairOneHot = 3'b001; end
      OP_ADDHL_N: begin isAddImm = 1'b1; pairOneHot = 3'b100; end
      OP_ADDDE_N: begin isAddImm = 1'b1; pairOneHot = 3'b010; end
      OP_ADDBC_N: begin isAddImm = 1'b1; pairOneHot = 3'b001; end
      OP_MULDE:   isMul    = 1'b1;
      OP_MIRROR:  isMirror = 1'b1;
      OP_SWAPNIB: isSwap   = 1'b1;
      OP_TESTIMM: isTest   = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    stb           = '0;
    stb.live      = opValid;
    stb.selSwap   = opValid & isSwap;
    stb.selMirror = opValid & isMirror;
    stb.selTest   = opValid & isTest;
    stb.selMul    = opValid & isMul;
    stb.selAddA   = opValid & isAddA;
    stb.selAddImm = opValid & isAddImm;
    stb.pairHL    = opValid & pairOneHot[2];
    stb.pairDE    = opValid & pairOneHot[1];
    stb.pairBC    = opValid & pairOneHot[0];
    stb.wrA       = opValid & (isSwap | isMirror);
    stb.wrF       = opValid & isTest;
    stb.wrHL      = opValid & pairOneHot[2];
    stb.wrDE      = opValid & (pairOneHot[1] | isMul);
    stb.wrBC      = opValid & pairOneHot[0];
  end

endmodule

// File: rtl/xalu_dpath.sv
module xalu_dpath
  import xalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  xaluStrobe_t         stb,
  input  logic [DATA_W-1:0]   inA,
  input  logic [DATA_W-1:0]   inF,
  input  logic [2*DATA_W-1:0] inBC,
  input  logic [2*DATA_W-1:0] inDE,
  input  logic [2*DATA_W-1:0] inHL,
  input  logic [2*DATA_W-1:0] inImm,
  output logic [DATA_W-1:0]   outA,
  output logic [DATA_W-1:0]   outF,
  output logic [2*DATA_W-1:0] outBC,
  output logic [2*DATA_W-1:0] outDE,
  output logic [2*DATA_W-1:0] outHL,
  output logic                weA,
  output logic                weF,
  output logic                weBC,
  output logic                weDE,
  output logic                weHL,
  output logic                outValid
);

  localparam int WORD_W = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;

  // ---------------- bit mirror ----------------
  logic [DATA_W-1:0] mirA;
  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
    assign mirA[i] = inA[DATA_W-1-i];
  end

  // ---------------- nibble swap ----------------
  logic [DATA_W-1:0] swapA;
  assign swapA = {inA[HALF_W-1:0], inA[DATA_W-1:HALF_W]};

  // ---------------- 8x8 multiply (shift-add array) ----------------
  logic [DATA_W-1:0] mulX;
  logic [DATA_W-1:0] mulY;
  logic [WORD_W-1:0] partial [DATA_W];
  logic [WORD_W-1:0] mulProd;

  assign mulX = inDE[WORD_W-1:DATA_W];
  assign mulY = inDE[DATA_W-1:0];

  for (genvar j = 0; j < DATA_W; j++) begin : g_partial
    assign partial[j] = mulY[j] ? ({{DATA_W{1'b0}}, mulX} << j) : '0;
  end

  always_comb begin
    mulProd = '0;
    for (int k = 0; k < DATA_W; k++) begin
      mulProd = mulProd + partial[k];
    end
  end

  // ---------------- pair adder ----------------
  logic [WORD_W-1:0] pairOperand;
  logic [WORD_W-1:0] addend;
  logic [WORD_W-1:0] pairSum;

  always_comb begin
    pairOperand = '0;
    if (stb.pairHL) pairOperand = inHL;
    if (stb.pairDE) pairOperand = inDE;
    if (stb.pairBC) pairOperand = inBC;
  end

  assign addend  = stb.selAddImm ? inImm : {{DATA_W{1'b0}}, inA};
  assign pairSum = pairOperand + addend;

  // ---------------- flag-only AND ----------------
  logic [DATA_W-1:0] andRes;
  logic [DATA_W-1:0] testFlags;

  assign andRes = inA & inImm[DATA_W-1:0];

  always_comb begin
    testFlags          = '0;
    testFlags[FLAG_S]  = andRes[DATA_W-1];
    testFlags[FLAG_Z]  = (andRes == '0);
    testFlags[FLAG_Y]  = andRes[FLAG_Y];
    testFlags[FLAG_H]  = 1'b1;
    testFlags[FLAG_X]  = andRes[FLAG_X];
    testFlags[FLAG_PV] = ~^andRes;
    testFlags[FLAG_N]  = 1'b0;
    testFlags[FLAG_C]  = 1'b0;
  end

  // ---------------- next-value selection ----------------
  logic [DATA_W-1:0] nextA;
  logic [DATA_W-1:0] nextF;
  logic [WORD_W-1:0] nextBC;
  logic [WORD_W-1:0] nextDE;
  logic [WORD_W-1:0] nextHL;

  always_comb begin
    nextA  = inA;
    nextF  = inF;
    nextBC = inBC;
    nextDE = inDE;
    nextHL = inHL;
    if (stb.selMirror) nextA = mirA;
    if (stb.selSwap)   nextA = swapA;
    if (stb.selTest)   nextF = testFlags;
    if (stb.selMul)    nextDE = mulProd;
    if (stb.wrHL)      nextHL = pairSum;
    if (stb.wrBC)      nextBC = pairSum;
    if (stb.wrDE && !stb.selMul) nextDE = pairSum;
  end

  // ---------------- output register ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outA     <= '0;
      outF     <= '0;
      outBC    <= '0;
      outDE    <= '0;
      outHL    <= '0;
      weA      <= 1'b0;
      weF      <= 1'b0;
      weBC     <= 1'b0;
      weDE     <= 1'b0;
      weHL     <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outA     <= nextA;
      outF     <= nextF;
      outBC    <= nextBC;
      outDE    <= nextDE;
      outHL    <= nextHL;
      weA      <= stb.wrA;
      weF      <= stb.wrF;
      weBC     <= stb.wrBC;
      weDE     <= stb.wrDE;
      weHL     <= stb.wrHL;
      outValid <= stb.live;
    end
  end

  // ---------------- assertions ----------------
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> !(weA || weF || weBC || weDE || weHL)); // R2

  AST_ONE_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({weA, weF, weBC, weDE, weHL}) <= 1); // R10

  AST_ADD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stb.selAddA || stb.selAddImm) |-> !weF && outF == $past(inF)); // R5

  AST_MUL_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stb.selMul) |-> weDE && !weF &&
      outDE == ({{DATA_W{1'b0}}, $past(inDE[WORD_W-1:DATA_W])} *
                {{DATA_W{1'b0}}, $past(inDE[DATA_W-1:0])})); // R6

  AST_TEST_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
    weF |-> !weA && outA == $past(inA)); // R9

  AST_TEST_H_SET: assert property (@(posedge clk) disable iff (!rst_n)
    weF |-> outF[FLAG_H] && !outF[FLAG_N] && !outF[FLAG_C]); // R9

endmodule

// File: rtl/xalu_unit.sv
module xalu_unit
  import xalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                opValid,
  input  logic [7:0]          opCode,
  input  logic [DATA_W-1:0]   inA,
  input  logic [DATA_W-1:0]   inF,
  input  logic [2*DATA_W-1:0] inBC,
  input  logic [2*DATA_W-1:0] inDE,
  input  logic [2*DATA_W-1:0] inHL,
  input  logic [2*DATA_W-1:0] inImm,
  output logic [DATA_W-1:0]   outA,
  output logic [DATA_W-1:0]   outF,
  output logic [2*DATA_W-1:0] outBC,
  output logic [2*DATA_W-1:0] outDE,
  output logic [2*DATA_W-1:0] outHL,
  output logic                weA,
  output logic                weF,
  output logic                weBC,
  output logic                weDE,
  output logic                weHL,
  output logic                outValid
);

  xaluStrobe_t stb;

  xalu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .stb     (stb)
  );

  xalu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .inA      (inA),
    .inF      (inF),
    .inBC     (inBC),
    .inDE     (inDE),
    .inHL     (inHL),
    .inImm    (inImm),
    .outA     (outA),
    .outF     (outF),
    .outBC    (outBC),
    .outDE    (outDE),
    .outHL    (outHL),
    .weA      (weA),
    .weF      (weF),
    .weBC     (weBC),
    .weDE     (weDE),
    .weHL     (weHL),
    .outValid (outValid)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> !outValid && !weA && !weF && !weBC && !weDE && !weHL); // R1

endmodule

// File: tb/sim_xalu_unit.sv
module sim_xalu_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opCode = '0;
  logic [7:0]  inA = '0;
  logic [7:0]  inF = '0;
  logic [15:0] inBC = '0;
  logic [15:0] inDE = '0;
  logic [15:0] inHL = '0;
  logic [15:0] inImm = '0;
  logic [7:0]  outA;
  logic [7:0]  outF;
  logic [15:0] outBC;
  logic [15:0] outDE;
  logic [15:0] outHL;
  logic        weA, weF, weBC, weDE, weHL, outValid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xalu_unit u0 (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .inA(inA), .inF(inF), .inBC(inBC), .inDE(inDE), .inHL(inHL), .inImm(inImm),
    .outA(outA), .outF(outF), .outBC(outBC), .outDE(outDE), .outHL(outHL),
    .weA(weA), .weF(weF), .weBC(weBC), .weDE(weDE), .weHL(weHL),
    .outValid(outValid)
  );

  function automatic logic [7:0] refMirror(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [7:0] refTestFlags(input logic [7:0] a, input logic [7:0] n);
    logic [7:0] r;
    int ones;
    r = a & n;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    return {r[7], (r == 8'h00), r[5], 1'b1, r[3], (ones % 2 == 0), 1'b0, 1'b0};
  endfunction

  task automatic checkVal(input string req, input string what,
                          input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Present one operation, wait for the edge, then compare all outputs.
  task automatic runOp(input string req, input logic [7:0] op,
                       input logic [7:0] a, input logic [7:0] f,
                       input logic [15:0] bc, input logic [15:0] de,
                       input logic [15:0] hl, input logic [15:0] imm);
    logic [7:0]  eA, eF;
    logic [15:0] eBC, eDE, eHL;
    logic [4:0]  eWe; // {A,F,BC,DE,HL}
    eA = a; eF = f; eBC = bc; eDE = de; eHL = hl; eWe = 5'b0;
    case (op)
      8'h31: begin eHL = hl + {8'h00, a}; eWe = 5'b00001; end
      8'h32: begin eDE = de + {8'h00, a}; eWe = 5'b00010; end
      8'h33: begin eBC = bc + {8'h00, a}; eWe = 5'b00100; end
      8'h34: begin eHL = hl + imm; eWe = 5'b00001; end
      8'h35: begin eDE = de + imm; eWe = 5'b00010; end
      8'h36: begin eBC = bc + imm; eWe = 5'b00100; end
      8'h30: begin eDE = 16'(de[15:8]) * 16'(de[7:0]); eWe = 5'b00010; end
      8'h24: begin eA = refMirror(a); eWe = 5'b10000; end
      8'h23: begin eA = {a[3:0], a[7:4]}; eWe = 5'b10000; end
      8'h27: begin eF = refTestFlags(a, imm[7:0]); eWe = 5'b01000; end
      default: ;
    endcase
    @(negedge clk);
    opValid = 1'b1; opCode = op; inA = a; inF = f;
    inBC = bc; inDE = de; inHL = hl; inImm = imm;
    @(negedge clk);
    checkVal(req, "outValid", 16'(outValid), 16'h1);
    checkVal(req, "write-enables", 16'({weA, weF, weBC, weDE, weHL}), 16'(eWe));
    checkVal(req, "outA", 16'(outA), 16'(eA));
    checkVal(req, "outF", 16'(outF), 16'(eF));
    checkVal(req, "outBC", outBC, eBC);
    checkVal(req, "outDE", outDE, eDE);
    checkVal(req, "outHL", outHL, eHL);
    opValid = 1'b0;
  endtask

  function automatic string reqOf(input logic [7:0] op);
    case (op)
      8'h31, 8'h32, 8'h33: return "R3/R5";
      8'h34, 8'h35, 8'h36: return "R4/R5";
      8'h30: return "R6";
      8'h24: return "R7";
      8'h23: return "R8";
      8'h27: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stimulus
    logic [7:0] ops [10];
    int seedDummy;
    ops = '{8'h23, 8'h24, 8'h27, 8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36};
    seedDummy = $urandom(32'h5eed_1234);

    // R1: reset state
    repeat (3) @(negedge clk);
    checkVal("R1", "outputs in reset",
             16'({outValid, weA, weF, weBC, weDE, weHL}) | 16'(outA) | outBC | outDE | outHL,
             16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    checkVal("R1", "first cycle after reset", 16'({outValid, weA, weF, weBC, weDE, weHL}), 16'h0);

    // Directed corners
    runOp("R3", 8'h31, 8'hFF, 8'hA5, 16'h1111, 16'h2222, 16'hFFF0, 16'h0);
    runOp("R3", 8'h33, 8'h80, 8'h00, 16'hFF80, 16'h0, 16'h0, 16'hFFFF);
    runOp("R4", 8'h35, 8'h12, 8'h3C, 16'h0, 16'hFFFF, 16'h0, 16'h0001);
    runOp("R4", 8'h34, 8'h00, 8'hFF, 16'h0, 16'h0, 16'h8000, 16'h8000);
    runOp("R5", 8'h36, 8'h01, 8'hD7, 16'h1234, 16'h0, 16'h0, 16'h4321);
    runOp("R6", 8'h30, 8'h00, 8'h5A, 16'h0, 16'hFFFF, 16'h0, 16'h0);
    runOp("R6", 8'h30, 8'h00, 8'h00, 16'h0, 16'h00C3, 16'h0, 16'h0);
    runOp("R6", 8'h30, 8'h00, 8'h00, 16'h0, 16'h0D0B, 16'h0, 16'h0);
    runOp("R7", 8'h24, 8'h01, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0);
    runOp("R7", 8'h24, 8'hC2, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0);
    runOp("R8", 8'h23, 8'h1E, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0);
    runOp("R9", 8'h27, 8'hF0, 8'hFF, 16'h0, 16'h0, 16'h0, 16'h000F); // zero result
    runOp("R9", 8'h27, 8'hFF, 8'h00, 16'h0, 16'h0, 16'h0, 16'h00A8); // odd parity
    runOp("R9", 8'h27, 8'hFF, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0028); // even parity
    runOp("R10", 8'h25, 8'h77, 8'h11, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD);
    runOp("R10", 8'h37, 8'h77, 8'h11, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD);

    // R2: idle cycle drops valid and every write-enable
    @(negedge clk);
    checkVal("R2", "idle outputs", 16'({outValid, weA, weF, weBC, weDE, weHL}), 16'h0);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [7:0] op;
      int pick;
      pick = int'($urandom_range(0, 11));
      if (pick < 10) op = ops[pick];
      else op = 8'($urandom());
      runOp(reqOf(op), op, 8'($urandom()), 8'($urandom()), 16'($urandom()),
            16'($urandom()), 16'($urandom()), 16'($urandom()));
      if ($urandom_range(0, 5) == 0) begin
        @(negedge clk);
        checkVal("R2", "idle after random op",
                 16'({outValid, weA, weF, weBC, weDE, weHL}), 16'h0);
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule